// File: doc/BRIEF.md
# Trace Event Qualifier with Start/Stop Window

This block watches an on-chip command bus and decides, one command at a time, whether the command should be recorded by a trace store further down the line. Each command carries a command code, a source ID, a destination ID and an address. The block holds three qualification sets: a filter, a start trigger and a stop trigger. Each set has a per-code command mask, a per-ID source mask, a per-ID destination mask, and an address compare value paired with an address mask. The block produces a one-cycle capture strobe and keeps track of whether a trigger window is open.

With triggering off, the strobe follows the filter alone. With triggering on, recording is limited to a window that a start-trigger match opens and a stop-trigger match closes. Inside the window, a command that matches the filter, the start trigger or the stop trigger is recorded. Idle bus cycles and response traffic are never recorded. All configuration arrives on plain register inputs held steady by the surrounding logic.

Top module: `trace_qualifier`

## Requirements
- R1: A command matches a set only when all four parts hit: the command mask bit indexed by the command code, the source mask bit indexed by the source ID, the destination mask bit indexed by the destination ID, and the address test.
- R2: The address test passes when ((address XOR compare value) AND address mask) is zero, so mask bits at 0 are don't-care positions.
- R3: With trigEn low, capStrobe is set for exactly those commands that match the filter set, and winOpen stays low.
- R4: A cycle with cmdValid low, or with command code IDLE_CODE (default 0) or RESP_CODE (default all ones), never raises capStrobe, whatever the masks hold.
- R5: After reset, capStrobe and winOpen are both low; capStrobe for a command presented in one cycle is high during the following cycle.
- R6: With trigEn high and the window closed, a start-trigger match is captured and winOpen is high from the next cycle.
- R7: While the window is open, a command is captured if it matches the filter, the start trigger or the stop trigger, and is not captured otherwise.
- R8: A stop-trigger match inside the window is captured and winOpen is low from the next cycle.
- R9: With trigEn high and the window closed, a command that matches only the filter or only the stop trigger is not captured and the window stays closed.
- R10: A command that matches both start and stop triggers while the window is closed is captured and leaves the window closed.
- R11: Lowering trigEn closes an open window from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigEn | input | 1 | Enables start/stop window gating |
| filtCmdMask | input | 2**CMD_W | Filter: one bit per command code |
| filtSrcMask | input | 2**SRC_W | Filter: one bit per source ID |
| filtDstMask | input | 2**DST_W | Filter: one bit per destination ID |
| filtAddrCmp | input | ADDR_W | Filter: address compare value |
| filtAddrMask | input | ADDR_W | Filter: address bits that take part in the compare |
| startCmdMask | input | 2**CMD_W | Start trigger: command mask |
| startSrcMask | input | 2**SRC_W | Start trigger: source mask |
| startDstMask | input | 2**DST_W | Start trigger: destination mask |
| startAddrCmp | input | ADDR_W | Start trigger: address compare value |
| startAddrMask | input | ADDR_W | Start trigger: address mask |
| stopCmdMask | input | 2**CMD_W | Stop trigger: command mask |
| stopSrcMask | input | 2**SRC_W | Stop trigger: source mask |
| stopDstMask | input | 2**DST_W | Stop trigger: destination mask |
| stopAddrCmp | input | ADDR_W | Stop trigger: address compare value |
| stopAddrMask | input | ADDR_W | Stop trigger: address mask |
| cmdValid | input | 1 | A command is present this cycle |
| cmdCode | input | CMD_W | Command code |
| cmdSrc | input | SRC_W | Source ID |
| cmdDst | input | DST_W | Destination ID |
| cmdAddr | input | ADDR_W | Command address |
| capStrobe | output | 1 | Record the command presented in the previous cycle |
| winOpen | output | 1 | Trigger window is open |

## Verification
The bench builds the block with a 4-bit command code, 5-bit source and destination IDs and a 12-bit address. The narrow code field puts the idle code and the response code at the two ends of a 16-bit command mask, so setting every mask bit shows directly that both stay unrecorded while their neighbours are recorded. The short address makes a masked compare with mixed care and don't-care nibbles easy to aim at, and the small ID masks let single cleared bits exercise each sub-match on its own.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int NUM_SETS  = 3;
  localparam int SET_FILT  = 0;
  localparam int SET_START = 1;
  localparam int SET_STOP  = 2;

  // Qualified hits from the datapath to the window control
  typedef struct packed {
    logic filt;
    logic start;
    logic stop;
  } hit_t;
endpackage

// File: rtl/tq_matcher.sv
module tq_matcher #(
  parameter int CMD_W  = 6,
  parameter int SRC_W  = 5,
  parameter int DST_W  = 5,
  parameter int ADDR_W = 38
) (
  input  logic [CMD_W-1:0]        cmdCode,
  input  logic [SRC_W-1:0]        cmdSrc,
  input  logic [DST_W-1:0]        cmdDst,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [(1<<CMD_W)-1:0]   cmdMask,
  input  logic [(1<<SRC_W)-1:0]   srcMask,
  input  logic [(1<<DST_W)-1:0]   dstMask,
  input  logic [ADDR_W-1:0]       addrCmp,
  input  logic [ADDR_W-1:0]       addrMask,
  output logic                    hit
);
  logic cmdHit, srcHit, dstHit, addrHit;

  always_comb begin
    cmdHit  = cmdMask[cmdCode];
    srcHit  = srcMask[cmdSrc];
    dstHit  = dstMask[cmdDst];
    addrHit = ((cmdAddr ^ addrCmp) & addrMask) == '0;
    hit     = cmdHit & srcHit & dstHit & addrHit;
  end
endmodule

// File: rtl/tq_datapath.sv
module tq_datapath
  import tq_pkg::*;
#(
  parameter int              CMD_W     = 6,
  parameter int              SRC_W     = 5,
  parameter int              DST_W     = 5,
  parameter int              ADDR_W    = 38,
  parameter logic [CMD_W-1:0] IDLE_CODE = '0,
  parameter logic [CMD_W-1:0] RESP_CODE = '1
) (
  input  logic                                  cmdValid,
  input  logic [CMD_W-1:0]                      cmdCode,
  input  logic [SRC_W-1:0]                      cmdSrc,
  input  logic [DST_W-1:0]                      cmdDst,
  input  logic [ADDR_W-1:0]                     cmdAddr,
  input  logic [NUM_SETS-1:0][(1<<CMD_W)-1:0]   cmdMaskArr,
  input  logic [NUM_SETS-1:0][(1<<SRC_W)-1:0]   srcMaskArr,
  input  logic [NUM_SETS-1:0][(1<<DST_W)-1:0]   dstMaskArr,
  input  logic [NUM_SETS-1:0][ADDR_W-1:0]       addrCmpArr,
  input  logic [NUM_SETS-1:0][ADDR_W-1:0]       addrMaskArr,
  output hit_t                                  hits
);
  logic                legal;
  logic [NUM_SETS-1:0] rawHit;

  // Idle cycles and response traffic are excluded ahead of all masks
  assign legal = cmdValid && (cmdCode != IDLE_CODE) && (cmdCode != RESP_CODE);

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    tq_matcher #(
      .CMD_W (CMD_W),
      .SRC_W (SRC_W),
      .DST_W (DST_W),
      .ADDR_W(ADDR_W)
    ) u_match (
      .cmdCode (cmdCode),
      .cmdSrc  (cmdSrc),
      .cmdDst  (cmdDst),
      .cmdAddr (cmdAddr),
      .cmdMask (cmdMaskArr[g]),
      .srcMask (srcMaskArr[g]),
      .dstMask (dstMaskArr[g]),
      .addrCmp (addrCmpArr[g]),
      .addrMask(addrMaskArr[g]),
      .hit     (rawHit[g])
    );
  end

  always_comb begin
    hits.filt  = legal & rawHit[SET_FILT];
    hits.start = legal & rawHit[SET_START];
    hits.stop  = legal & rawHit[SET_STOP];
  end
endmodule

// File: rtl/tq_control.sv
module tq_control
  import tq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trigEn,
  input  hit_t hits,
  output logic capStrobe,
  output logic winOpen
);
  logic inWindow;
  logic capNext;
  logic winNext;

  always_comb begin
    if (!trigEn) begin
      inWindow = 1'b0;
      capNext  = hits.filt;
      winNext  = 1'b0;
    end else begin
      // A start hit opens the window for its own cycle
      inWindow = winOpen | hits.start;
      capNext  = inWindow & (hits.filt | hits.start | hits.stop);
      // A stop hit is recorded, then the window shuts
      winNext  = inWindow & ~hits.stop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capStrobe <= 1'b0;
      winOpen   <= 1'b0;
    end else begin
      capStrobe <= capNext;
      winOpen   <= winNext;
    end
  end
endmodule

// File: rtl/trace_qualifier.sv
module trace_qualifier
  import tq_pkg::*;
#(
  parameter int               CMD_W     = 6,
  parameter int               SRC_W     = 5,
  parameter int               DST_W     = 5,
  parameter int               ADDR_W    = 38,
  parameter logic [CMD_W-1:0] IDLE_CODE = '0,
  parameter logic [CMD_W-1:0] RESP_CODE = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trigEn,
  input  logic [(1<<CMD_W)-1:0]   filtCmdMask,
  input  logic [(1<<SRC_W)-1:0]   filtSrcMask,
  input  logic [(1<<DST_W)-1:0]   filtDstMask,
  input  logic [ADDR_W-1:0]       filtAddrCmp,
  input  logic [ADDR_W-1:0]       filtAddrMask,
  input  logic [(1<<CMD_W)-1:0]   startCmdMask,
  input  logic [(1<<SRC_W)-1:0]   startSrcMask,
  input  logic [(1<<DST_W)-1:0]   startDstMask,
  input  logic [ADDR_W-1:0]       startAddrCmp,
  input  logic [ADDR_W-1:0]       startAddrMask,
  input  logic [(1<<CMD_W)-1:0]   stopCmdMask,
  input  logic [(1<<SRC_W)-1:0]   stopSrcMask,
  input  logic [(1<<DST_W)-1:0]   stopDstMask,
  input  logic [ADDR_W-1:0]       stopAddrCmp,
  input  logic [ADDR_W-1:0]       stopAddrMask,
  input  logic                    cmdValid,
  input  logic [CMD_W-1:0]        cmdCode,
  input  logic [SRC_W-1:0]        cmdSrc,
  input  logic [DST_W-1:0]        cmdDst,
  input  logic [ADDR_W-1:0]       cmdAddr,
  output logic                    capStrobe,
  output logic                    winOpen
);
  localparam int CMD_N = 1 << CMD_W;
  localparam int SRC_N = 1 << SRC_W;
  localparam int DST_N = 1 << DST_W;

  logic [NUM_SETS-1:0][CMD_N-1:0]  cmdMaskArr;
  logic [NUM_SETS-1:0][SRC_N-1:0]  srcMaskArr;
  logic [NUM_SETS-1:0][DST_N-1:0]  dstMaskArr;
  logic [NUM_SETS-1:0][ADDR_W-1:0] addrCmpArr;
  logic [NUM_SETS-1:0][ADDR_W-1:0] addrMaskArr;
  hit_t                            hitBus;

  always_comb begin
    cmdMaskArr[SET_FILT]   = filtCmdMask;
    srcMaskArr[SET_FILT]   = filtSrcMask;
    dstMaskArr[SET_FILT]   = filtDstMask;
    addrCmpArr[SET_FILT]   = filtAddrCmp;
    addrMaskArr[SET_FILT]  = filtAddrMask;
    cmdMaskArr[SET_START]  = startCmdMask;
    srcMaskArr[SET_START]  = startSrcMask;
    dstMaskArr[SET_START]  = startDstMask;
    addrCmpArr[SET_START]  = startAddrCmp;
    addrMaskArr[SET_START] = startAddrMask;
    cmdMaskArr[SET_STOP]   = stopCmdMask;
    srcMaskArr[SET_STOP]   = stopSrcMask;
    dstMaskArr[SET_STOP]   = stopDstMask;
    addrCmpArr[SET_STOP]   = stopAddrCmp;
    addrMaskArr[SET_STOP]  = stopAddrMask;
  end

  tq_datapath #(
    .CMD_W    (CMD_W),
    .SRC_W    (SRC_W),
    .DST_W    (DST_W),
    .ADDR_W   (ADDR_W),
    .IDLE_CODE(IDLE_CODE),
    .RESP_CODE(RESP_CODE)
  ) u_dp (
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdSrc     (cmdSrc),
    .cmdDst     (cmdDst),
    .cmdAddr    (cmdAddr),
    .cmdMaskArr (cmdMaskArr),
    .srcMaskArr (srcMaskArr),
    .dstMaskArr (dstMaskArr),
    .addrCmpArr (addrCmpArr),
    .addrMaskArr(addrMaskArr),
    .hits       (hitBus)
  );

  tq_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .trigEn   (trigEn),
    .hits     (hitBus),
    .capStrobe(capStrobe),
    .winOpen  (winOpen)
  );
endmodule

// File: rtl/tq_checker.sv
module tq_checker
  import tq_pkg::*;
#(
  parameter int               CMD_W     = 6,
  parameter logic [CMD_W-1:0] IDLE_CODE = '0,
  parameter logic [CMD_W-1:0] RESP_CODE = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             trigEn,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdCode,
  input hit_t             hits,
  input logic             capStrobe,
  input logic             winOpen
);
  AST_IDLE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdCode == IDLE_CODE || cmdCode == RESP_CODE) |=> !capStrobe); // R4

  AST_NO_WINDOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !trigEn |=> !winOpen); // R3

  AST_FILTER_ONLY: assert property (@(posedge clk) disable iff (rst)
    !trigEn |=> capStrobe == $past(hits.filt)); // R3

  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    (trigEn && hits.start && !hits.stop) |=> (winOpen && capStrobe)); // R6

  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (trigEn && hits.stop) |=> !winOpen); // R8

  AST_STOP_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (trigEn && hits.stop && (winOpen || hits.start)) |=> capStrobe); // R10

  AST_CLOSED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (trigEn && !winOpen && !hits.start) |=> !capStrobe); // R9
endmodule

bind trace_qualifier tq_checker #(
  .CMD_W    (CMD_W),
  .IDLE_CODE(IDLE_CODE),
  .RESP_CODE(RESP_CODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .trigEn   (trigEn),
  .cmdValid (cmdValid),
  .cmdCode  (cmdCode),
  .hits     (hitBus),
  .capStrobe(capStrobe),
  .winOpen  (winOpen)
);

// File: tb/sim_trace_qualifier.sv
`timescale 1ns/1ps
module sim_trace_qualifier;
  localparam int CW = 4;
  localparam int SW = 5;
  localparam int DW = 5;
  localparam int AW = 12;
  localparam int CN = 1 << CW;
  localparam int SN = 1 << SW;
  localparam int DN = 1 << DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigEn = 1'b0;
  logic [CN-1:0] cM [3];
  logic [SN-1:0] sM [3];
  logic [DN-1:0] dM [3];
  logic [AW-1:0] aC [3];
  logic [AW-1:0] aM [3];
  logic          v = 1'b0;
  logic [CW-1:0] code = '0;
  logic [SW-1:0] src = '0;
  logic [DW-1:0] dst = '0;
  logic [AW-1:0] addr = '0;
  logic          capStrobe;
  logic          winOpen;

  typedef struct {
    bit    cap;
    bit    win;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit mWin = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_qualifier #(.CMD_W(CW), .SRC_W(SW), .DST_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .trigEn(trigEn),
    .filtCmdMask(cM[0]), .filtSrcMask(sM[0]), .filtDstMask(dM[0]),
    .filtAddrCmp(aC[0]), .filtAddrMask(aM[0]),
    .startCmdMask(cM[1]), .startSrcMask(sM[1]), .startDstMask(dM[1]),
    .startAddrCmp(aC[1]), .startAddrMask(aM[1]),
    .stopCmdMask(cM[2]), .stopSrcMask(sM[2]), .stopDstMask(dM[2]),
    .stopAddrCmp(aC[2]), .stopAddrMask(aM[2]),
    .cmdValid(v), .cmdCode(code), .cmdSrc(src), .cmdDst(dst), .cmdAddr(addr),
    .capStrobe(capStrobe), .winOpen(winOpen)
  );

  function automatic bit setHit(int i);
    return cM[i][code] && sM[i][src] && dM[i][dst] &&
           (((addr ^ aC[i]) & aM[i]) == '0);
  endfunction

  // Driver: present one command, push the expected outcome, wait one cycle
  task automatic send(input bit vv, input int cc, input int ss, input int dd,
                      input int aa, input string tag);
    bit legal, hf, hs, hp, inw, cap, nwin;
    v = vv; code = cc[CW-1:0]; src = ss[SW-1:0]; dst = dd[DW-1:0]; addr = aa[AW-1:0];
    legal = vv && (cc != 0) && (cc != CN - 1);
    hf = legal && setHit(0);
    hs = legal && setHit(1);
    hp = legal && setHit(2);
    if (!trigEn) begin
      cap = hf; nwin = 1'b0;
    end else begin
      inw  = mWin || hs;
      cap  = inw && (hf || hs || hp);
      nwin = inw && !hp;
    end
    mWin = nwin;
    q.push_back('{cap, nwin, tag});
    @(negedge clk);
  endtask

  // Monitor: compare after each edge that follows a pushed command
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (capStrobe !== e.cap || winOpen !== e.win) begin
        errors++;
        $display("FAIL %s: cap=%0b win=%0b expected cap=%0b win=%0b",
                 e.tag, capStrobe, winOpen, e.cap, e.win);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      cM[i] = '0; sM[i] = '1; dM[i] = '1; aC[i] = '0; aM[i] = '0;
    end
    cM[0] = 16'h0028;
    repeat (3) @(negedge clk);
    checks++;
    if (capStrobe !== 1'b0 || winOpen !== 1'b0) begin
      errors++;
      $display("FAIL R5 reset: cap=%0b win=%0b expected cap=0 win=0", capStrobe, winOpen);
    end
    rst = 1'b0;
    @(negedge clk);

    // Filter only
    send(1, 3, 1, 1, 0, "R3 R5 filter hit");
    send(1, 4, 1, 1, 0, "R1 command miss");
    sM[0][2] = 1'b0;
    send(1, 3, 2, 1, 0, "R1 source miss");
    send(1, 3, 3, 1, 0, "R1 source hit");
    dM[0][7] = 1'b0;
    send(1, 5, 3, 7, 0, "R1 destination miss");
    aC[0] = 12'h0A0; aM[0] = 12'h0F0;
    send(1, 5, 3, 1, 12'h3A7, "R2 masked address hit");
    send(1, 5, 3, 1, 12'h0B0, "R2 address miss");
    aM[0] = '0;

    // Excluded traffic
    cM[0] = '1;
    send(0, 3, 1, 1, 0, "R4 not valid");
    send(1, 0, 1, 1, 0, "R4 idle code");
    send(1, 15, 1, 1, 0, "R4 response code");
    send(1, 14, 1, 1, 0, "R4 legal neighbour");

    // Trigger window
    cM[0] = 16'h0008; cM[1] = 16'h0002; cM[2] = 16'h0004;
    trigEn = 1'b1;
    send(1, 3, 1, 1, 0, "R9 filter outside window");
    send(1, 2, 1, 1, 0, "R9 stop outside window");
    send(1, 1, 1, 1, 0, "R6 start opens");
    send(1, 3, 1, 1, 0, "R7 filter inside");
    send(1, 4, 1, 1, 0, "R7 miss inside");
    send(1, 1, 1, 1, 0, "R7 start inside");
    cM[0] = '1;
    send(1, 15, 1, 1, 0, "R4 response inside window");
    cM[0] = 16'h0008;
    send(1, 2, 1, 1, 0, "R8 stop closes");
    send(1, 3, 1, 1, 0, "R9 filter after stop");
    cM[2] = 16'h0006;
    send(1, 1, 1, 1, 0, "R10 start and stop together");
    send(1, 3, 1, 1, 0, "R10 window stays closed");
    cM[2] = 16'h0004;
    send(1, 1, 1, 1, 0, "R6 reopen");
    trigEn = 1'b0;
    send(0, 0, 0, 0, 0, "R11 disable closes window");
    send(1, 3, 1, 1, 0, "R3 filter after disable");

    v = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule